// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailbox Interrupts

This block is a synchronous memory that two agents, called left and right, share. Each side has its own select, write strobe, output gate, address and data lanes. Either side can read or write any word, and both sides can access the memory in the same clock cycle. Read data is registered. It appears on the cycle after the read and stays there until that side reads again.

The two highest word addresses also serve as mailboxes between the agents. The lower of the two belongs to the left side and the top one belongs to the right side. When the mailbox function is switched on, a write by one side into the other side's mailbox raises an active-low attention flag toward the owner. The owner drops its flag by reading its own mailbox. The word in a mailbox is ordinary data that the agents define. When the mailbox function is switched off, both addresses are plain memory and the flags hold their values.

The depth is a parameter. The default build has 4K words. An 8K-word build uses `ADDR_W = 13`, which places the mailboxes at 0x1FFE (left) and 0x1FFF (right). Every access completes in one cycle, so the ports have no back-pressure and no handshake.

Top module: `dpm_mailbox_top`

## Requirements
- R1: A side with select low and write strobe high reads. The word shows on its read lane on the next cycle. A side with select low and write strobe low writes its data word into the addressed location. If the other side writes the same address in the same cycle, the read returns the old word.
- R2: While a side's output gate is high, its read lane shows all zeros. The registered read word is kept, and it shows again once the gate goes low.
- R3: With the mailbox function on, a right-side write to address DEPTH-2 drives the left attention output low from the next cycle. A left-side write to DEPTH-2 does not raise the left flag.
- R4: With the mailbox function on, a left-side read of DEPTH-2 (select low, write strobe high, output gate of any value) returns the left attention output high from the next cycle.
- R5: With the mailbox function on, a left-side write to address DEPTH-1 drives the right attention output low. A right-side read of DEPTH-1 returns it high.
- R6: If a set and a clear of the same flag occur in one cycle, the flag ends up raised.
- R7: With the mailbox function off, neither flag changes. The mailbox addresses still store and return data like any other word.
- R8: A side whose select is high makes no access. It leaves the memory, its read register and both flags unchanged.
- R9: During reset both attention outputs are high and both read registers hold zero.
- R10: If both sides write the same address in one cycle, the right side's word is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous reset, active low |
| mbox_en | input | 1 | High switches the mailbox flags on |
| lft_sel_n | input | 1 | Left select, active low |
| lft_wr_n | input | 1 | Left write strobe, active low |
| lft_oe_n | input | 1 | Left output gate, active low |
| lft_addr | input | ADDR_W | Left word address |
| lft_wdata | input | DATA_W | Left write data |
| lft_rdata | output | DATA_W | Left read data |
| lft_attn_n | output | 1 | Left attention flag, active low |
| rgt_sel_n | input | 1 | Right select, active low |
| rgt_wr_n | input | 1 | Right write strobe, active low |
| rgt_oe_n | input | 1 | Right output gate, active low |
| rgt_addr | input | ADDR_W | Right word address |
| rgt_wdata | input | DATA_W | Right write data |
| rgt_rdata | output | DATA_W | Right read data |
| rgt_attn_n | output | 1 | Right attention flag, active low |

## Verification
A flag can be set and cleared in the same cycle: the peer writes a mailbox while its owner reads that same mailbox. Random traffic reaches this case because half of all addresses point at the two mailboxes. A directed step forces it on each flag, and the check expects the flag to stay low, since the set wins. A directed step also writes a mailbox from one side while the other side reads it, and the check expects the read to return the old word.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  function automatic acc_e classify(input logic sel_n, input logic wr_n);
    if (sel_n)      return ACC_IDLE;
    else if (wr_n)  return ACC_READ;
    else            return ACC_WRITE;
  endfunction
endpackage

// File: rtl/dpm_port_decode.sv
module dpm_port_decode
  import dpm_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int MB_OWN  = 4094,
  parameter int MB_PEER = 4095
) (
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_en,
  output logic              wr_en,
  output logic              own_read,
  output logic              peer_write
);
  localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(MB_OWN);
  localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(MB_PEER);

  acc_e kind;

  always_comb begin
    kind       = classify(sel_n, wr_n);
    rd_en      = (kind == ACC_READ);
    wr_en      = (kind == ACC_WRITE);
    own_read   = rd_en && (addr == OWN_A);
    peer_write = wr_en && (addr == PEER_A);
  end
endmodule

// File: rtl/dpm_bank.sv
module dpm_bank #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_rd,
  input  logic              a_wr,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_q,
  input  logic              b_rd,
  input  logic              b_wr,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  // Port b is written last, so it wins a same-address collision.
  always_ff @(posedge clk) begin
    if (a_wr) store[a_addr] <= a_wdata;
    if (b_wr) store[b_addr] <= b_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (a_rd) a_q <= store[a_addr];
      if (b_rd) b_q <= store[b_addr];
    end
  end
endmodule

// File: rtl/dpm_mbox_flag.sv
module dpm_mbox_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic set_req,
  input  logic clr_req,
  output logic raised
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            raised <= 1'b0;
    else if (enable) begin
      if (set_req)         raised <= 1'b1;
      else if (clr_req)    raised <= 1'b0;
    end
  end
endmodule

// File: rtl/dpm_mailbox_top.sv
module dpm_mailbox_top #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mbox_en,
  input  logic              lft_sel_n,
  input  logic              lft_wr_n,
  input  logic              lft_oe_n,
  input  logic [ADDR_W-1:0] lft_addr,
  input  logic [DATA_W-1:0] lft_wdata,
  output logic [DATA_W-1:0] lft_rdata,
  output logic              lft_attn_n,
  input  logic              rgt_sel_n,
  input  logic              rgt_wr_n,
  input  logic              rgt_oe_n,
  input  logic [ADDR_W-1:0] rgt_addr,
  input  logic [DATA_W-1:0] rgt_wdata,
  output logic [DATA_W-1:0] rgt_rdata,
  output logic              rgt_attn_n
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int MB_LEFT  = DEPTH - 2;
  localparam int MB_RIGHT = DEPTH - 1;
  localparam int SIDES    = 2;

  logic              sel_n_v  [SIDES];
  logic              wr_n_v   [SIDES];
  logic [ADDR_W-1:0] addr_v   [SIDES];
  logic              rd_v     [SIDES];
  logic              wr_v     [SIDES];
  logic              ownrd_v  [SIDES];
  logic              peerwr_v [SIDES];
  logic              flag_v   [SIDES];
  logic [DATA_W-1:0] lq, rq;

  assign sel_n_v[0] = lft_sel_n;
  assign wr_n_v[0]  = lft_wr_n;
  assign addr_v[0]  = lft_addr;
  assign sel_n_v[1] = rgt_sel_n;
  assign wr_n_v[1]  = rgt_wr_n;
  assign addr_v[1]  = rgt_addr;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    localparam int OWN  = (s == 0) ? MB_LEFT  : MB_RIGHT;
    localparam int PEER = (s == 0) ? MB_RIGHT : MB_LEFT;

    dpm_port_decode #(.ADDR_W(ADDR_W), .MB_OWN(OWN), .MB_PEER(PEER)) u_dec (
      .sel_n      (sel_n_v[s]),
      .wr_n       (wr_n_v[s]),
      .addr       (addr_v[s]),
      .rd_en      (rd_v[s]),
      .wr_en      (wr_v[s]),
      .own_read   (ownrd_v[s]),
      .peer_write (peerwr_v[s])
    );

    // Flag of side s is set by the other side writing into s's mailbox.
    dpm_mbox_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (mbox_en),
      .set_req (peerwr_v[SIDES-1-s]),
      .clr_req (ownrd_v[s]),
      .raised  (flag_v[s])
    );
  end

  dpm_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_rd    (rd_v[0]),
    .a_wr    (wr_v[0]),
    .a_addr  (lft_addr),
    .a_wdata (lft_wdata),
    .a_q     (lq),
    .b_rd    (rd_v[1]),
    .b_wr    (wr_v[1]),
    .b_addr  (rgt_addr),
    .b_wdata (rgt_wdata),
    .b_q     (rq)
  );

  assign lft_rdata  = lft_oe_n ? '0 : lq;
  assign rgt_rdata  = rgt_oe_n ? '0 : rq;
  assign lft_attn_n = ~flag_v[0];
  assign rgt_attn_n = ~flag_v[1];
endmodule

// File: rtl/dpm_mailbox_chk.sv
module dpm_mailbox_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mbox_en,
  input logic              lft_sel_n,
  input logic              lft_wr_n,
  input logic [ADDR_W-1:0] lft_addr,
  input logic [DATA_W-1:0] lft_rdata,
  input logic              lft_oe_n,
  input logic              lft_attn_n,
  input logic              rgt_sel_n,
  input logic              rgt_wr_n,
  input logic [ADDR_W-1:0] rgt_addr,
  input logic              rgt_attn_n
);
  localparam logic [ADDR_W-1:0] MBL = ADDR_W'((1 << ADDR_W) - 2);
  localparam logic [ADDR_W-1:0] MBR = ADDR_W'((1 << ADDR_W) - 1);

  logic l_set, r_set, l_clr, r_clr;
  assign l_set = !rgt_sel_n && !rgt_wr_n && rgt_addr == MBL;
  assign r_set = !lft_sel_n && !lft_wr_n && lft_addr == MBR;
  assign l_clr = !lft_sel_n && lft_wr_n && lft_addr == MBL;
  assign r_clr = !rgt_sel_n && rgt_wr_n && rgt_addr == MBR;

  a_r9_reset_inactive: assert property (@(posedge clk)
    !rst_n |=> (lft_attn_n && rgt_attn_n));

  a_r3_left_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_en && l_set) |=> !lft_attn_n);

  a_r5_right_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_en && r_set) |=> !rgt_attn_n);

  a_r4_left_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_en && l_clr && !l_set) |=> lft_attn_n);

  a_r5_right_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_en && r_clr && !r_set) |=> rgt_attn_n);

  a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mbox_en |=> ($stable(lft_attn_n) && $stable(rgt_attn_n)));

  a_r8_standby_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lft_sel_n && rgt_sel_n) |=> ($stable(lft_attn_n) && $stable(rgt_attn_n)));

  a_r2_gate_zero: assert property (@(posedge clk) disable iff (!rst_n)
    lft_oe_n |-> (lft_rdata == '0));
endmodule

bind dpm_mailbox_top dpm_mailbox_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mbox_en    (mbox_en),
  .lft_sel_n  (lft_sel_n),
  .lft_wr_n   (lft_wr_n),
  .lft_addr   (lft_addr),
  .lft_rdata  (lft_rdata),
  .lft_oe_n   (lft_oe_n),
  .lft_attn_n (lft_attn_n),
  .rgt_sel_n  (rgt_sel_n),
  .rgt_wr_n   (rgt_wr_n),
  .rgt_addr   (rgt_addr),
  .rgt_attn_n (rgt_attn_n)
);

// File: tb/test_dpm_mailbox_top.sv
`timescale 1ns/1ps
module test_dpm_mailbox_top;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] MBL = AW'(DEPTH - 2);
  localparam logic [AW-1:0] MBR = AW'(DEPTH - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mbox_en = 1'b0;
  logic lft_sel_n = 1'b1, lft_wr_n = 1'b1, lft_oe_n = 1'b0;
  logic rgt_sel_n = 1'b1, rgt_wr_n = 1'b1, rgt_oe_n = 1'b0;
  logic [AW-1:0] lft_addr = '0, rgt_addr = '0;
  logic [DW-1:0] lft_wdata = '0, rgt_wdata = '0;
  logic [DW-1:0] lft_rdata, rgt_rdata;
  logic lft_attn_n, rgt_attn_n;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] m_lq = '0, m_rq = '0;
  bit m_lf = 0, m_rf = 0;

  always #2.5 clk = ~clk;

  dpm_mailbox_top #(.ADDR_W(AW), .DATA_W(DW)) i_dpm_mailbox_top (.*);

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] gated(input logic oe_n, input logic [DW-1:0] q);
    return oe_n ? '0 : q;
  endfunction

  task automatic check_all();
    chk("R1 R2 left rdata", lft_rdata, gated(lft_oe_n, m_lq));
    chk("R1 R2 right rdata", rgt_rdata, gated(rgt_oe_n, m_rq));
    chk("R3 R4 R6 left attn", {15'd0, lft_attn_n}, {15'd0, !m_lf});
    chk("R5 R6 right attn", {15'd0, rgt_attn_n}, {15'd0, !m_rf});
  endtask

  // Check current outputs, apply one cycle of stimulus, advance the model,
  // then return at the next falling edge.
  task automatic cyc(input logic en,
                     input logic ls, input logic lw, input logic lo,
                     input logic [AW-1:0] la, input logic [DW-1:0] ld,
                     input logic rs, input logic rw, input logic ro,
                     input logic [AW-1:0] ra, input logic [DW-1:0] rd);
    bit lrd, lwr, rrd, rwr, ls_set, rs_set, lc, rc;
    check_all();
    mbox_en = en;
    lft_sel_n = ls; lft_wr_n = lw; lft_oe_n = lo; lft_addr = la; lft_wdata = ld;
    rgt_sel_n = rs; rgt_wr_n = rw; rgt_oe_n = ro; rgt_addr = ra; rgt_wdata = rd;
    lrd = !ls && lw;  lwr = !ls && !lw;
    rrd = !rs && rw;  rwr = !rs && !rw;
    if (lrd) m_lq = mem[la];
    if (rrd) m_rq = mem[ra];
    if (lwr) mem[la] = ld;
    if (rwr) mem[ra] = rd;
    ls_set = rwr && ra == MBL;  lc = lrd && la == MBL;
    rs_set = lwr && la == MBR;  rc = rrd && ra == MBR;
    if (en) begin
      if (ls_set) m_lf = 1; else if (lc) m_lf = 0;
      if (rs_set) m_rf = 1; else if (rc) m_rf = 0;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(1'b1, 1'b1, 1'b1, 1'b0, '0, '0, 1'b1, 1'b1, 1'b0, '0, '0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 left attn in reset", {15'd0, lft_attn_n}, 16'd1);
    chk("R9 right attn in reset", {15'd0, rgt_attn_n}, 16'd1);
    chk("R9 left rdata in reset", lft_rdata, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Preload with mailbox off so no flag moves (R7).
    for (int a = 0; a < 16; a++)
      cyc(1'b0, 1'b0, 1'b0, 1'b0, AW'(a), DW'(16'h1000 + a), 1'b1, 1'b1, 1'b0, '0, '0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, MBL, 16'hAAAA, 1'b0, 1'b0, 1'b0, MBR, 16'h5555);
    chk("R7 left attn idle after preload", {15'd0, lft_attn_n}, 16'd1);
    chk("R7 right attn idle after preload", {15'd0, rgt_attn_n}, 16'd1);

    // R3: right writes left mailbox; R1 left reads old word same cycle.
    cyc(1'b1, 1'b0, 1'b1, 1'b0, MBL, '0, 1'b0, 1'b0, 1'b0, MBL, 16'hBEEF);
    chk("R3 left attn raised", {15'd0, lft_attn_n}, 16'd0);
    chk("R1 old word on collision read", lft_rdata, 16'hAAAA);
    // R4: left clearing read with output gate high.
    cyc(1'b1, 1'b0, 1'b1, 1'b1, MBL, '0, 1'b1, 1'b1, 1'b0, '0, '0);
    chk("R4 left attn cleared", {15'd0, lft_attn_n}, 16'd1);
    chk("R2 gated lane zero", lft_rdata, 16'd0);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, '0, '0, 1'b1, 1'b1, 1'b0, '0, '0);
    chk("R2 held word reappears", lft_rdata, 16'hBEEF);
    // R3: left writing its own mailbox does not raise its flag.
    cyc(1'b1, 1'b0, 1'b0, 1'b0, MBL, 16'h0001, 1'b1, 1'b1, 1'b0, '0, '0);
    chk("R3 own write no flag", {15'd0, lft_attn_n}, 16'd1);
    // R5: left writes right mailbox, then right reads it.
    cyc(1'b1, 1'b0, 1'b0, 1'b0, MBR, 16'hC0DE, 1'b1, 1'b1, 1'b0, '0, '0);
    chk("R5 right attn raised", {15'd0, rgt_attn_n}, 16'd0);
    // R8: right deselected read attempt leaves the flag.
    cyc(1'b1, 1'b1, 1'b1, 1'b0, '0, '0, 1'b1, 1'b1, 1'b0, MBR, '0);
    chk("R8 deselected no clear", {15'd0, rgt_attn_n}, 16'd0);
    // R7: mailbox off, the read does not clear, data still returned.
    cyc(1'b0, 1'b1, 1'b1, 1'b0, '0, '0, 1'b0, 1'b1, 1'b0, MBR, '0);
    chk("R7 no clear when off", {15'd0, rgt_attn_n}, 16'd0);
    chk("R7 mailbox data readable", rgt_rdata, 16'hC0DE);
    // R6: right reads own mailbox while left writes it again: set wins.
    cyc(1'b1, 1'b0, 1'b0, 1'b0, MBR, 16'h7777, 1'b0, 1'b1, 1'b0, MBR, '0);
    chk("R6 set wins right", {15'd0, rgt_attn_n}, 16'd0);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, '0, '0, 1'b0, 1'b1, 1'b0, MBR, '0);
    chk("R5 right attn cleared", {15'd0, rgt_attn_n}, 16'd1);
    chk("R6 new word after set", rgt_rdata, 16'h7777);
    // R6 on left flag.
    cyc(1'b1, 1'b0, 1'b1, 1'b0, MBL, '0, 1'b0, 1'b0, 1'b0, MBL, 16'h4242);
    chk("R6 set wins left", {15'd0, lft_attn_n}, 16'd0);
    // R10: both write same address, right word kept.
    cyc(1'b1, 1'b0, 1'b0, 1'b0, AW'(5), 16'h1111, 1'b0, 1'b0, 1'b0, AW'(5), 16'h2222);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, AW'(5), '0, 1'b1, 1'b1, 1'b0, '0, '0);
    chk("R10 right wins collision", lft_rdata, 16'h2222);
    // R8: deselected write does not store.
    cyc(1'b1, 1'b1, 1'b0, 1'b0, AW'(6), 16'hDEAD, 1'b1, 1'b1, 1'b0, '0, '0);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, AW'(6), '0, 1'b1, 1'b1, 1'b0, '0, '0);
    chk("R8 deselected write ignored", lft_rdata, 16'h1006);

    // Random traffic, model checked every cycle.
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] la, ra;
      la = ($urandom % 2) ? (MBL + AW'($urandom % 2)) : AW'($urandom % 16);
      ra = ($urandom % 2) ? (MBL + AW'($urandom % 2)) : AW'($urandom % 16);
      cyc(($urandom % 8) != 0,
          ($urandom % 8) == 0, $urandom % 2, ($urandom % 4) == 0, la, DW'($urandom),
          ($urandom % 8) == 0, $urandom % 2, ($urandom % 4) == 0, ra, DW'($urandom));
    end
    idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule